// File: doc/BRIEF.md
# Bus Direction Control State Machine

This block watches a half-duplex carrier link and decides who owns a downstream RS-485 bus. When a received burst starts, it raises a direction output so the local bus drivers can forward the whole message. When the local side starts sending, it drops into a transmit hold instead. Each hold lasts a rate-dependent window of about sixteen bit times. The window restarts on every new piece of activity of the same kind. When the window runs out without activity, the block returns to idle.

A two-bit rate select picks one of three hold windows. Its fourth code puts the block in standby. In standby the transmit path is disabled and the state machine is held in idle. The select inputs are synchronised inside the block. The receive data, its rising-edge strobe and the transmit data are taken as already synchronous to the clock.

Top module: `bus_dir_ctrl`

## Requirements
- R1: After reset, `dir_o`, `tx_mode_o` and `standby_o` are all low, and the block is idle with rate select 2'b00 assumed.
- R2: In idle and outside standby, a low on `rx_data_i` (carrier present) at a clock edge enters the receive hold, and `dir_o` is high after that edge.
- R3: In idle and outside standby, with `rx_data_i` high, a low on `tx_data_i` at a clock edge enters the transmit hold. After that edge `tx_mode_o` is high and `dir_o` is low.
- R4: The receive hold is reloaded at every edge where `rx_data_i` is low or `rx_rise_i` is high. It ends exactly T edges after the last reload edge. `dir_o` is still high after edge T-1 and low after edge T.
- R5: The transmit hold is reloaded at every edge where `tx_data_i` is low. It ends exactly T edges after the last such edge.
- R6: T is SLOW_CYC for select 2'b00, MED_CYC for 2'b01 and FAST_CYC for 2'b10. The defaults are 14510, 3630 and 1192 cycles.
- R7: Select 2'b11 is standby. While it is in force, `standby_o` is high, `dir_o` and `tx_mode_o` are low, a low on `tx_data_i` or `rx_data_i` enters no hold, and the state is forced to idle. After standby is left, the block is idle.
- R8: During the receive hold, `tx_data_i` changes neither the mode nor the hold length. During the transmit hold, receive activity neither raises `dir_o` nor extends the hold.
- R9: If `rx_data_i` and `tx_data_i` are both low at the same edge in idle, the receive hold wins.
- R10: A new rate select has no effect on a countdown already running. The new value is used from the next reload onward.
- R11: `rate_sel_i` passes through a two-stage synchroniser. A change made between edges shows on `standby_o` after the second following edge, and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_data_i | input | 1 | Transmit data; low means the local transmitter is sending carrier |
| rx_data_i | input | 1 | Demodulated receive data; low means carrier present |
| rx_rise_i | input | 1 | One-cycle strobe on a rising edge of the receive data |
| rate_sel_i | input | 2 | Rate select: 00 slow, 01 medium, 10 fast, 11 standby |
| dir_o | output | 1 | High while the downstream bus is claimed for received data |
| tx_mode_o | output | 1 | High while the transmit hold is active |
| standby_o | output | 1 | High while the synchronised select is the standby code |

## Verification
Two cases are hard to reach from the ports. The first is a rate change that lands while a countdown is already running. The bench reaches it by issuing a single short burst, so the only reload happens at the rising-edge strobe. It then switches the select during the hold. The drop of `dir_o` must then come at the old window length, and the next burst must use the new one. The second case is activity of the opposite kind during a hold. The bench drives it at counted offsets from the last reload, so that any spurious retrigger would move the exact edge at which the hold ends.

// File: rtl/bdc_pkg.sv
package bdc_pkg;

  typedef enum logic [1:0] {
    LINK_IDLE = 2'd0,
    LINK_RECV = 2'd1,
    LINK_XMIT = 2'd2
  } link_state_e;

  localparam logic [1:0] SEL_SLOW = 2'b00;
  localparam logic [1:0] SEL_MED  = 2'b01;
  localparam logic [1:0] SEL_FAST = 2'b10;
  localparam logic [1:0] SEL_STBY = 2'b11;

  // Hold window length in clock cycles for a given rate code.
  function automatic int unsigned hold_cycles(input logic [1:0] sel,
                                              input int unsigned slow_c,
                                              input int unsigned med_c,
                                              input int unsigned fast_c);
    case (sel)
      SEL_MED:  return med_c;
      SEL_FAST: return fast_c;
      default:  return slow_c;
    endcase
  endfunction

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/bdc_sync.sv
module bdc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/bdc_hold_timer.sv
module bdc_hold_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt_q <= '0;
    else if (clear_i)                  cnt_q <= '0;
    else if (load_i)                   cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  // Last cycle of the window: the next edge ends the hold.
  assign expire_o = run_i && !load_i && !clear_i && (cnt_q == CNT_W'(1));
  assign cnt_o    = cnt_q;

endmodule

// File: rtl/bdc_mode_fsm.sv
module bdc_mode_fsm
  import bdc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        standby_i,
  input  logic        rx_data_i,
  input  logic        rx_rise_i,
  input  logic        tx_data_i,
  input  logic        expire_i,
  output link_state_e state_o,
  output logic        load_o,
  output logic        run_o
);

  link_state_e state_q, state_d;
  logic rx_act, tx_act;

  assign rx_act = !rx_data_i;
  assign tx_act = !tx_data_i;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    if (standby_i) begin
      state_d = LINK_IDLE;
    end else begin
      case (state_q)
        LINK_IDLE: begin
          if (rx_act) begin
            state_d = LINK_RECV;   // receive has priority
            load_o  = 1'b1;
          end else if (tx_act) begin
            state_d = LINK_XMIT;
            load_o  = 1'b1;
          end
        end
        LINK_RECV: begin
          if (rx_act || rx_rise_i) load_o  = 1'b1;
          else if (expire_i)       state_d = LINK_IDLE;
        end
        LINK_XMIT: begin
          if (tx_act)              load_o  = 1'b1;
          else if (expire_i)       state_d = LINK_IDLE;
        end
        default: state_d = LINK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LINK_IDLE;
    else        state_q <= state_d;
  end

  assign state_o = state_q;
  assign run_o   = (state_q != LINK_IDLE);

endmodule

// File: rtl/bus_dir_ctrl.sv
module bus_dir_ctrl
  import bdc_pkg::*;
#(
  parameter int unsigned SLOW_CYC = 14510,
  parameter int unsigned MED_CYC  = 3630,
  parameter int unsigned FAST_CYC = 1192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_data_i,
  input  logic       rx_data_i,
  input  logic       rx_rise_i,
  input  logic [1:0] rate_sel_i,
  output logic       dir_o,
  output logic       tx_mode_o,
  output logic       standby_o
);

  localparam int unsigned MAX_CYC = max3(SLOW_CYC, MED_CYC, FAST_CYC);
  localparam int          CNT_W   = $clog2(MAX_CYC + 1);

  logic [1:0]       sel_s;
  logic             standby_w;
  logic             load_w;
  logic             run_w;
  logic             expire_w;
  logic [CNT_W-1:0] load_val_w;
  logic [CNT_W-1:0] cnt_w;
  link_state_e      state_w;

  bdc_sync #(.W(2), .STAGES(2)) u_sel_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_i   (rate_sel_i),
    .q_o   (sel_s)
  );

  assign standby_w  = (sel_s == SEL_STBY);
  assign load_val_w = CNT_W'(hold_cycles(sel_s, SLOW_CYC, MED_CYC, FAST_CYC));

  bdc_mode_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .standby_i (standby_w),
    .rx_data_i (rx_data_i),
    .rx_rise_i (rx_rise_i),
    .tx_data_i (tx_data_i),
    .expire_i  (expire_w),
    .state_o   (state_w),
    .load_o    (load_w),
    .run_o     (run_w)
  );

  bdc_hold_timer #(.CNT_W(CNT_W)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (standby_w),
    .load_i     (load_w),
    .load_val_i (load_val_w),
    .run_i      (run_w),
    .cnt_o      (cnt_w),
    .expire_o   (expire_w)
  );

  assign standby_o = standby_w;
  assign dir_o     = (state_w == LINK_RECV) && !standby_w;
  assign tx_mode_o = (state_w == LINK_XMIT) && !standby_w;

endmodule

// File: rtl/bus_dir_ctrl_chk.sv
module bus_dir_ctrl_chk #(
  parameter int CNT_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_data_i,
  input logic             tx_data_i,
  input logic             dir_o,
  input logic             tx_mode_o,
  input logic             standby_o,
  input logic [CNT_W-1:0] hold_cnt,
  input logic             reload,
  input logic             expire
);

  assert_rx_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_o && !tx_mode_o && !standby_o && !rx_data_i) |=> (dir_o || standby_o));

  assert_tx_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dir_o && !tx_mode_o && !standby_o && rx_data_i && !tx_data_i) |=> (tx_mode_o || standby_o));

  assert_expire_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (!dir_o && !tx_mode_o));

  assert_countdown_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((dir_o || tx_mode_o) && !reload && !standby_o && hold_cnt > CNT_W'(1))
      |=> (hold_cnt == $past(hold_cnt) - CNT_W'(1)));

  assert_tx_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_mode_o && !tx_data_i && !standby_o) |=> (tx_mode_o || standby_o));

  assert_standby_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    standby_o |=> (hold_cnt == '0 && !dir_o && !tx_mode_o));

  assert_no_tx_from_rx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_mode_o) |-> $past(!dir_o));

  assert_no_rx_from_tx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dir_o) |-> $past(!tx_mode_o));

endmodule

bind bus_dir_ctrl bus_dir_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_data_i (rx_data_i),
  .tx_data_i (tx_data_i),
  .dir_o     (dir_o),
  .tx_mode_o (tx_mode_o),
  .standby_o (standby_o),
  .hold_cnt  (cnt_w),
  .reload    (load_w),
  .expire    (expire_w)
);

// File: tb/sim_bus_dir_ctrl.sv
`timescale 1ns/1ps
module sim_bus_dir_ctrl;

  localparam int T_SLOW = 40;
  localparam int T_MED  = 20;
  localparam int T_FAST = 10;
  localparam int WD_CYC = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_data = 1'b1;
  logic       rx_data = 1'b1;
  logic       rx_rise = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic       dir, tx_mode, standby;

  int checks = 0;
  int errors = 0;
  logic cur_sb = 1'b0;

  always #2.5 clk = ~clk;

  bus_dir_ctrl #(.SLOW_CYC(T_SLOW), .MED_CYC(T_MED), .FAST_CYC(T_FAST)) u0 (
    .clk(clk), .rst_n(rst_n), .tx_data_i(tx_data), .rx_data_i(rx_data),
    .rx_rise_i(rx_rise), .rate_sel_i(rate_sel),
    .dir_o(dir), .tx_mode_o(tx_mode), .standby_o(standby)
  );

  task automatic check(input logic act, input logic exp, input string tag, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Caller stands at a negedge just after the last reload edge.
  task automatic expect_hold(input bit is_tx, input int t, input string tag);
    repeat (t - 1) @(posedge clk);
    @(negedge clk);
    check(is_tx ? tx_mode : dir, 1'b1, tag, "hold still on at T-1");
    @(posedge clk);
    @(negedge clk);
    check(is_tx ? tx_mode : dir, 1'b0, tag, "hold off at T");
  endtask

  // Carrier for low_n cycles, then release with the rising strobe.
  task automatic rx_burst(input int low_n);
    @(negedge clk);
    rx_data = 1'b0;
    repeat (low_n) @(negedge clk);
    rx_data = 1'b1;
    rx_rise = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rx_rise = 1'b0;
  endtask

  task automatic set_rate(input logic [1:0] sel);
    logic new_sb;
    new_sb = (sel == 2'b11);
    @(negedge clk);
    rate_sel = sel;
    @(negedge clk);
    check(standby, cur_sb, "R11", "standby after one edge");
    @(negedge clk);
    check(standby, new_sb, "R11", "standby after two edges");
    cur_sb = new_sb;
  endtask

  task automatic t_reset;
    @(negedge clk);
    check(dir, 1'b0, "R1", "dir in reset");
    check(tx_mode, 1'b0, "R1", "tx_mode in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(dir, 1'b0, "R1", "dir after reset");
    check(tx_mode, 1'b0, "R1", "tx_mode after reset");
    check(standby, 1'b0, "R1", "standby after reset");
  endtask

  task automatic t_rx_basic;
    @(negedge clk);
    rx_data = 1'b0;
    @(negedge clk);
    check(dir, 1'b1, "R2", "dir on carrier");
    check(tx_mode, 1'b0, "R2", "no tx_mode on carrier");
    repeat (3) @(negedge clk);
    rx_data = 1'b1;
    rx_rise = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rx_rise = 1'b0;
    repeat (12) @(negedge clk);
    check(dir, 1'b1, "R4", "dir mid window");
    rx_burst(2);
    expect_hold(1'b0, T_SLOW, "R4");
  endtask

  task automatic t_tx_basic;
    @(negedge clk);
    tx_data = 1'b0;
    @(negedge clk);
    check(tx_mode, 1'b1, "R3", "tx_mode on send");
    check(dir, 1'b0, "R3", "dir low on send");
    repeat (4) @(negedge clk);
    tx_data = 1'b1;
    expect_hold(1'b1, T_SLOW, "R5");
  endtask

  task automatic t_rates;
    set_rate(2'b01);
    rx_burst(1);
    expect_hold(1'b0, T_MED, "R6");
    set_rate(2'b10);
    rx_burst(1);
    expect_hold(1'b0, T_FAST, "R6");
    set_rate(2'b00);
  endtask

  task automatic t_exclusive;
    rx_burst(1);
    tx_data = 1'b0;
    repeat (5) @(negedge clk);
    check(tx_mode, 1'b0, "R8", "no tx_mode during receive");
    check(dir, 1'b1, "R8", "dir kept during tx low");
    tx_data = 1'b1;
    expect_hold(1'b0, T_SLOW - 5, "R8");
    check(tx_mode, 1'b0, "R8", "idle after receive hold");
    @(negedge clk);
    tx_data = 1'b0;
    @(negedge clk);
    tx_data = 1'b1;
    rx_burst(2);
    check(dir, 1'b0, "R8", "dir low during transmit");
    expect_hold(1'b1, T_SLOW - 4, "R8");
    check(dir, 1'b0, "R8", "dir low after transmit hold");
  endtask

  task automatic t_both;
    @(negedge clk);
    rx_data = 1'b0;
    tx_data = 1'b0;
    @(negedge clk);
    check(dir, 1'b1, "R9", "receive wins dir");
    check(tx_mode, 1'b0, "R9", "receive wins tx_mode");
    tx_data = 1'b1;
    rx_data = 1'b1;
    rx_rise = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rx_rise = 1'b0;
    expect_hold(1'b0, T_SLOW, "R9");
  endtask

  task automatic t_rate_change;
    rx_burst(1);
    rate_sel = 2'b10;
    expect_hold(1'b0, T_SLOW, "R10");
    rx_burst(1);
    expect_hold(1'b0, T_FAST, "R10");
    set_rate(2'b00);
  endtask

  task automatic t_standby;
    rx_burst(1);
    set_rate(2'b11);
    check(dir, 1'b0, "R7", "dir low in standby");
    @(negedge clk);
    tx_data = 1'b0;
    rx_data = 1'b0;
    repeat (3) @(negedge clk);
    check(tx_mode, 1'b0, "R7", "tx ignored in standby");
    check(dir, 1'b0, "R7", "rx ignored in standby");
    tx_data = 1'b1;
    rx_data = 1'b1;
    set_rate(2'b00);
    check(dir, 1'b0, "R7", "idle after standby dir");
    check(tx_mode, 1'b0, "R7", "idle after standby tx_mode");
    repeat (3) @(negedge clk);
    check(dir, 1'b0, "R7", "no resumed hold");
  endtask

  initial begin
    t_reset();
    t_rx_basic();
    t_tx_basic();
    t_rates();
    t_exclusive();
    t_both();
    t_rate_change();
    t_standby();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(WD_CYC * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule